// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the transmit half of a descriptor-driven Ethernet DMA engine. Software builds a linked list of four-word descriptors in memory. Each descriptor holds a control word, the byte address of a frame buffer, a status-and-length word and the address of the next descriptor. Software hands each descriptor to the engine by setting its owner bit. It then enables transmission and pulses the demand input.

The walker fetches each descriptor it owns and streams the frame's bytes out on a byte-wide valid/ready stream. It then writes a completion status into the descriptor and gives the descriptor back to software by clearing the owner bit. After that it follows the next pointer. When it meets a descriptor that software still owns, it stops, flags that no descriptor is available, and keeps that descriptor's address. A later demand picks the walk up from that address.

A bus error response on any memory access halts the engine until reset. MAC framing, CRC, padding and collision handling belong to other blocks.

Top module: `txd_walker`

## Requirements
- R1: A descriptor at byte address D is read as four 32-bit words: control at D, buffer byte address at D+4, status-and-length at D+8 (frame length in bits 15:0), and next-descriptor address at D+12. The walker does not alter the buffer-address word or the next word.
- R2: Control bit 31 set means the engine owns the descriptor. When the walker reads a descriptor with bit 31 clear, it sets status bit 23, returns to idle, streams no bytes, writes nothing, and leaves `cur_desc` at that descriptor's address.
- R3: For an owned descriptor, exactly `length` bytes are streamed, taken from the buffer byte address upward. The byte at address A comes from bits 8*(A mod 4)+7 : 8*(A mod 4) of the word at A with its two low bits cleared. `tx_last` marks the final byte. Data and last hold while valid is high and ready is low. A zero length streams nothing but still completes.
- R4: After the bytes, the walker writes D+8 with the length in bits 15:0, bit 19 set, bit 16 equal to `cfg_txint_en`, and all other bits zero. It then writes D with bit 31 cleared and the other control bits unchanged. The status write always comes before the control write.
- R5: Every completed frame sets status bits 18 and 16.
- R6: A walk starts only on a `tx_demand` pulse while `cfg_tx_on` is high. The first walk after reset starts at `cfg_list_base`. A demand while `cfg_tx_on` is low issues no memory request.
- R7: After a completed frame, the next descriptor address is taken from word D+12, and `cur_desc` shows that address.
- R8: A demand after a stop resumes at `cur_desc` and reads that descriptor's control word again.
- R9: An error response to any access sets status bit 24 and halts the engine. After that there are no further memory requests, no stream output, and demands are ignored until reset.
- R10: `tx_irq` is high when any status bit is set together with its `cfg_irq_en` bit. `stat_clr` clears the status bits given by its set bits. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R11: Once `mem_req` is raised, it stays high, with address, write enable and write data held, until `mem_ack` is seen.
- R12: After reset, `tx_stat`, `cur_desc`, `mem_req`, `tx_valid` and `busy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_list_base | input | AW | Address of the first descriptor used after reset |
| cfg_tx_on | input | 1 | Transmission enable |
| cfg_txint_en | input | 1 | Selects whether bit 16 is set in the written-back descriptor status |
| cfg_irq_en | input | 32 | Per-bit interrupt enable for `tx_stat` |
| tx_demand | input | 1 | One-cycle pulse that starts or resumes a walk |
| stat_clr | input | 32 | One cycle, write-one-to-clear for `tx_stat` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| tx_stat | output | 32 | Interrupt status: bit 16 frame interrupt, bit 18 frame sent, bit 23 no descriptor, bit 24 bus error |
| tx_irq | output | 1 | Interrupt request |
| cur_desc | output | AW | Address of the current descriptor |
| busy | output | 1 | Walker is not idle |

## Verification
Two things can fall in the same cycle: a software clear of the frame-sent status bit, and the completion of a frame that sets the same bit. The bench provokes this by holding that clear active through a 36-frame walk, with the interrupt enabled only for that bit. Because a set wins over a clear, each frame must still produce exactly one cycle of `tx_irq`. The bench therefore counts the interrupt-high cycles against the number of frames, and checks that the bit reads zero once the walk is over.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
  // descriptor layout
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned LEN_W         = 16;
  localparam int unsigned WORD_BYTES    = 4;
  localparam int unsigned OWN_BIT       = 31;
  localparam int unsigned DSC_DONE_BIT  = 19;
  localparam int unsigned DSC_INT_BIT   = 16;
  // status register layout
  localparam int unsigned STAT_W         = 32;
  localparam int unsigned ST_INT_BIT     = 16;
  localparam int unsigned ST_SENT_BIT    = 18;
  localparam int unsigned ST_UNAVAIL_BIT = 23;
  localparam int unsigned ST_BUSERR_BIT  = 24;

  typedef enum logic [3:0] {
    W_IDLE,
    W_RD_CTRL,
    W_RD_BUF,
    W_RD_LEN,
    W_RD_NEXT,
    W_STREAM,
    W_WB_STAT,
    W_WB_CTRL,
    W_HALT
  } walk_state_t;
endpackage

// File: rtl/txd_walk_ctl.sv
`timescale 1ns/1ps
module txd_walk_ctl
  import txd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        list_base,
  input  logic                 tx_on,
  input  logic                 txint_en,
  input  logic                 demand,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [WORD_W-1:0]    mem_rdata,
  input  logic                 stream_done,
  output logic                 ctl_req,
  output logic                 ctl_we,
  output logic [AW-1:0]        ctl_addr,
  output logic [WORD_W-1:0]    ctl_wdata,
  output logic                 stream_go,
  output logic [AW-1:0]        buf_addr,
  output logic [LEN_W-1:0]     frame_len,
  output logic [AW-1:0]        cur_desc,
  output logic                 busy,
  output logic                 evt_sent,
  output logic                 evt_unavail,
  output logic                 evt_buserr
);
  localparam logic [AW-1:0] OFF_BUF  = AW'(1 * WORD_BYTES);
  localparam logic [AW-1:0] OFF_LEN  = AW'(2 * WORD_BYTES);
  localparam logic [AW-1:0] OFF_NEXT = AW'(3 * WORD_BYTES);

  walk_state_t          state_q, state_n;
  logic [AW-1:0]        cur_q, cur_n;
  logic [AW-1:0]        buf_q, buf_n;
  logic [AW-1:0]        nxt_q, nxt_n;
  logic [LEN_W-1:0]     len_q, len_n;
  logic [WORD_W-1:0]    ctrl_q, ctrl_n;
  logic                 fresh_q, fresh_n;
  logic                 ack_ok, ack_bad;
  logic [WORD_W-1:0]    stat_word;

  assign ack_ok  = mem_ack && !mem_err;
  assign ack_bad = mem_ack && mem_err;

  always_comb begin
    stat_word               = WORD_W'(len_q);
    stat_word[DSC_DONE_BIT] = 1'b1;
    stat_word[DSC_INT_BIT]  = txint_en;
  end

  // next-state process
  always_comb begin
    state_n     = state_q;
    cur_n       = cur_q;
    buf_n       = buf_q;
    nxt_n       = nxt_q;
    len_n       = len_q;
    ctrl_n      = ctrl_q;
    fresh_n     = fresh_q;
    ctl_req     = 1'b0;
    ctl_we      = 1'b0;
    ctl_addr    = cur_q;
    ctl_wdata   = '0;
    stream_go   = 1'b0;
    evt_sent    = 1'b0;
    evt_unavail = 1'b0;
    evt_buserr  = 1'b0;
    unique case (state_q)
      W_IDLE: begin
        if (demand && tx_on) begin
          state_n = W_RD_CTRL;
          fresh_n = 1'b0;
          if (fresh_q) cur_n = list_base;
        end
      end
      W_RD_CTRL: begin
        ctl_req = 1'b1;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (ack_ok) begin
          ctrl_n = mem_rdata;
          if (mem_rdata[OWN_BIT]) begin
            state_n = W_RD_BUF;
          end else begin
            state_n     = W_IDLE;
            evt_unavail = 1'b1;
          end
        end
      end
      W_RD_BUF: begin
        ctl_req  = 1'b1;
        ctl_addr = cur_q + OFF_BUF;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (ack_ok) begin
          buf_n   = mem_rdata[AW-1:0];
          state_n = W_RD_LEN;
        end
      end
      W_RD_LEN: begin
        ctl_req  = 1'b1;
        ctl_addr = cur_q + OFF_LEN;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (ack_ok) begin
          len_n   = mem_rdata[LEN_W-1:0];
          state_n = W_RD_NEXT;
        end
      end
      W_RD_NEXT: begin
        ctl_req  = 1'b1;
        ctl_addr = cur_q + OFF_NEXT;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (ack_ok) begin
          nxt_n   = mem_rdata[AW-1:0];
          state_n = W_STREAM;
        end
      end
      W_STREAM: begin
        stream_go = 1'b1;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (stream_done) begin
          state_n = W_WB_STAT;
        end
      end
      W_WB_STAT: begin
        ctl_req   = 1'b1;
        ctl_we    = 1'b1;
        ctl_addr  = cur_q + OFF_LEN;
        ctl_wdata = stat_word;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (ack_ok) begin
          state_n = W_WB_CTRL;
        end
      end
      W_WB_CTRL: begin
        ctl_req            = 1'b1;
        ctl_we             = 1'b1;
        ctl_wdata          = ctrl_q;
        ctl_wdata[OWN_BIT] = 1'b0;
        if (ack_bad) begin
          state_n    = W_HALT;
          evt_buserr = 1'b1;
        end else if (ack_ok) begin
          evt_sent = 1'b1;
          cur_n    = nxt_q;
          state_n  = tx_on ? W_RD_CTRL : W_IDLE;
        end
      end
      W_HALT:  state_n = W_HALT;
      default: state_n = W_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      cur_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      state_q <= state_n;
      cur_q   <= cur_n;
      fresh_q <= fresh_n;
    end
  end

  // descriptor field registers, no reset needed
  always_ff @(posedge clk) begin
    buf_q  <= buf_n;
    nxt_q  <= nxt_n;
    len_q  <= len_n;
    ctrl_q <= ctrl_n;
  end

  assign buf_addr  = buf_q;
  assign frame_len = len_q;
  assign cur_desc  = cur_q;
  assign busy      = (state_q != W_IDLE);
endmodule

// File: rtl/txd_byte_pump.sv
`timescale 1ns/1ps
module txd_byte_pump
  import txd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [AW-1:0]        base,
  input  logic [LEN_W-1:0]     len,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [WORD_W-1:0]    mem_rdata,
  input  logic                 tx_ready,
  output logic                 rd_req,
  output logic [AW-1:0]        rd_addr,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic                 tx_last,
  output logic                 done
);
  localparam int unsigned LANE_W = $clog2(WORD_BYTES);

  logic [LEN_W-1:0]   idx_q, idx_n;
  logic               have_q, have_n;
  logic [WORD_W-1:0]  word_q;
  logic               word_en;
  logic [AW-1:0]      byte_addr;
  logic [LANE_W-1:0]  lane;
  logic               accept;

  assign byte_addr = base + AW'(idx_q);
  assign lane      = byte_addr[LANE_W-1:0];
  assign rd_addr   = {byte_addr[AW-1:LANE_W], {LANE_W{1'b0}}};
  assign rd_req    = go && !have_q && (len != '0);
  assign tx_valid  = go && have_q;
  assign tx_data   = word_q[{lane, 3'b000} +: 8];
  assign tx_last   = tx_valid && (idx_q == len - 1'b1);
  assign accept    = tx_valid && tx_ready;
  assign done      = go && ((len == '0) || (accept && tx_last));
  assign word_en   = rd_req && mem_ack && !mem_err;

  // next-state process
  always_comb begin
    idx_n  = idx_q;
    have_n = have_q;
    if (!go) begin
      idx_n  = '0;
      have_n = 1'b0;
    end else begin
      if (word_en) have_n = 1'b1;
      if (accept) begin
        idx_n = idx_q + 1'b1;
        if ((lane == {LANE_W{1'b1}}) || tx_last) have_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      have_q <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      have_q <= have_n;
    end
  end

  always_ff @(posedge clk) begin
    if (word_en) word_q <= mem_rdata;
  end
endmodule

// File: rtl/txd_int_stat.sv
`timescale 1ns/1ps
module txd_int_stat
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_sent,
  input  logic              evt_unavail,
  input  logic              evt_buserr,
  input  logic [STAT_W-1:0] clr,
  input  logic [STAT_W-1:0] irq_en,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  localparam logic [STAT_W-1:0] IMPL_MASK =
      (STAT_W'(1) << ST_INT_BIT)     | (STAT_W'(1) << ST_SENT_BIT) |
      (STAT_W'(1) << ST_UNAVAIL_BIT) | (STAT_W'(1) << ST_BUSERR_BIT);

  logic [STAT_W-1:0] stat_q, stat_n, set_vec;
  logic              stat_en;

  always_comb begin
    set_vec                 = '0;
    set_vec[ST_INT_BIT]     = evt_sent;
    set_vec[ST_SENT_BIT]    = evt_sent;
    set_vec[ST_UNAVAIL_BIT] = evt_unavail;
    set_vec[ST_BUSERR_BIT]  = evt_buserr;
    // a set in the same cycle as a clear wins
    stat_n  = ((stat_q & ~clr) | set_vec) & IMPL_MASK;
    stat_en = (|set_vec) || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_n;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & irq_en);
endmodule

// File: rtl/txd_walker.sv
`timescale 1ns/1ps
module txd_walker
  import txd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cfg_list_base,
  input  logic              cfg_tx_on,
  input  logic              cfg_txint_en,
  input  logic [31:0]       cfg_irq_en,
  input  logic              tx_demand,
  input  logic [31:0]       stat_clr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic [31:0]       tx_stat,
  output logic              tx_irq,
  output logic [AW-1:0]     cur_desc,
  output logic              busy
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              ctl_req, ctl_we, pump_req;
  logic [AW-1:0]     ctl_addr, pump_addr, buf_addr;
  logic [31:0]       ctl_wdata;
  logic              stream_go, stream_done;
  logic [LEN_W-1:0]  frame_len;
  logic              evt_sent, evt_unavail, evt_buserr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  txd_walk_ctl #(.AW(AW)) u_ctl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .list_base   (cfg_list_base),
    .tx_on       (cfg_tx_on),
    .txint_en    (cfg_txint_en),
    .demand      (tx_demand),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .mem_rdata   (mem_rdata),
    .stream_done (stream_done),
    .ctl_req     (ctl_req),
    .ctl_we      (ctl_we),
    .ctl_addr    (ctl_addr),
    .ctl_wdata   (ctl_wdata),
    .stream_go   (stream_go),
    .buf_addr    (buf_addr),
    .frame_len   (frame_len),
    .cur_desc    (cur_desc),
    .busy        (busy),
    .evt_sent    (evt_sent),
    .evt_unavail (evt_unavail),
    .evt_buserr  (evt_buserr)
  );

  txd_byte_pump #(.AW(AW)) u_pump (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .go        (stream_go),
    .base      (buf_addr),
    .len       (frame_len),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_rdata (mem_rdata),
    .tx_ready  (tx_ready),
    .rd_req    (pump_req),
    .rd_addr   (pump_addr),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .done      (stream_done)
  );

  txd_int_stat u_stat (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .evt_sent    (evt_sent),
    .evt_unavail (evt_unavail),
    .evt_buserr  (evt_buserr),
    .clr         (stat_clr),
    .irq_en      (cfg_irq_en),
    .stat        (tx_stat),
    .irq         (tx_irq)
  );

  // the pump only requests while streaming, when the controller is silent
  assign mem_req   = ctl_req | pump_req;
  assign mem_we    = ctl_we;
  assign mem_addr  = stream_go ? pump_addr : ctl_addr;
  assign mem_wdata = ctl_wdata;
endmodule

// File: rtl/txd_walker_chk.sv
`timescale 1ns/1ps
module txd_walker_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_tx_on,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          mem_err,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          stat_unavail,
  input logic          stat_buserr
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R9
  berr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> stat_buserr);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_buserr |-> !mem_req && !tx_valid);

  // R2
  tdu_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_unavail) |-> !busy && !mem_req);

  // R6
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cfg_tx_on |=> !mem_req);
endmodule

bind txd_walker txd_walker_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_tx_on    (cfg_tx_on),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .mem_err      (mem_err),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last),
  .stat_unavail (tx_stat[txd_pkg::ST_UNAVAIL_BIT]),
  .stat_buserr  (tx_stat[txd_pkg::ST_BUSERR_BIT])
);

// File: tb/txd_walker_test.sv
`timescale 1ns/1ps
module txd_walker_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_list_base = '0;
  logic          cfg_tx_on = 1'b0;
  logic          cfg_txint_en = 1'b0;
  logic [31:0]   cfg_irq_en = '0;
  logic          tx_demand = 1'b0;
  logic [31:0]   stat_clr = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic          mem_err = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid, tx_last;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b0;
  logic [31:0]   tx_stat;
  logic          tx_irq;
  logic [AW-1:0] cur_desc;
  logic          busy;

  txd_walker #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_list_base(cfg_list_base), .cfg_tx_on(cfg_tx_on),
    .cfg_txint_en(cfg_txint_en), .cfg_irq_en(cfg_irq_en), .tx_demand(tx_demand),
    .stat_clr(stat_clr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_stat(tx_stat), .tx_irq(tx_irq), .cur_desc(cur_desc), .busy(busy)
  );

  logic [31:0] mem [0:1023];
  logic [7:0]  cap [0:2047];
  logic        stat_wr [0:63];
  int checks = 0, errors = 0;
  int cap_n = 0, last_n = 0, req_cnt = 0, irq_cnt = 0, order_err = 0, rdy_cnt = 0;
  bit finished = 0;

  // memory responder and stream sink
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      req_cnt++;
      mem_err = mem_addr[15];
      if (!mem_err) begin
        if (mem_we) begin
          if (mem_addr < 32'h400) begin
            if (mem_addr[3:2] == 2'd2) stat_wr[mem_addr[9:4]] = 1'b1;
            if (mem_addr[3:2] == 2'd0) begin
              if (!stat_wr[mem_addr[9:4]]) order_err++;
              stat_wr[mem_addr[9:4]] = 1'b0;
            end
          end
          mem[mem_addr[11:2]] = mem_wdata;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
        end
      end
    end
    rdy_cnt++;
    tx_ready = (rdy_cnt % 3) != 0;
    if (tx_valid && tx_ready) begin
      cap[cap_n] = tx_data;
      cap_n++;
      if (tx_last) last_n++;
    end
    if (tx_irq) irq_cnt++;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_desc(int a, logic [31:0] fl, int b, int len, int nx);
    mem[a >> 2]       = fl;
    mem[(a >> 2) + 1] = b;
    mem[(a >> 2) + 2] = 32'h00FF_0000 | len;
    mem[(a >> 2) + 3] = nx;
  endtask

  task automatic fill_buf(int b, int len);
    for (int k = 0; k < len; k++) mem[(b + k) >> 2][((b + k) % 4) * 8 +: 8] = pat(b + k);
  endtask

  task automatic pulse_demand();
    @(negedge clk) tx_demand = 1'b1;
    @(negedge clk) tx_demand = 1'b0;
  endtask

  task automatic pulse_clr(logic [31:0] m);
    @(negedge clk) stat_clr = m;
    @(negedge clk) stat_clr = '0;
  endtask

  task automatic wait_bit(int b, string req);
    int n = 0;
    while (!tx_stat[b] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 20000, req, n, 0);
  endtask

  function automatic int mismatches(int start, int b, int len);
    int m = 0;
    for (int k = 0; k < len; k++) if (cap[start + k] !== pat(b + k)) m++;
    return m;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_bytes, bad, start, rc;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) stat_wr[i] = 1'b0;
    do_reset();

    // R12 reset state
    chk(tx_stat == 0 && cur_desc == 0, "R12 stat/cur", tx_stat, 0);
    chk(!mem_req && !tx_valid && !busy, "R12 req/valid/busy", {mem_req, tx_valid, busy}, 0);

    // R6 demand without enable
    pulse_demand();
    repeat (20) @(negedge clk);
    chk(req_cnt == 0 && !busy, "R6 demand while disabled", req_cnt, 0);

    // sweep: offset 0..3 x length 0..8
    for (int i = 0; i < 36; i++) begin
      put_desc(i * 16, 32'h8000_0005 | (i << 8), 32'h400 + 16 * i + i % 4, i / 4, (i + 1) * 16);
      fill_buf(32'h400 + 16 * i + i % 4, i / 4);
    end
    put_desc(36 * 16, 32'h0000_0033, 32'h700, 2, 0);
    cfg_list_base = '0;
    cfg_tx_on = 1'b1;
    cfg_txint_en = 1'b1;
    cfg_irq_en = 32'h1 << 18;
    stat_clr = 32'h1 << 18;      // held: collides with every frame's set
    irq_cnt = 0;
    pulse_demand();
    stat_clr = 32'h1 << 18;
    wait_bit(23, "R2 unavailable after sweep");
    stat_clr = '0;
    cfg_irq_en = '0;
    @(negedge clk);

    exp_bytes = 0;
    bad = 0;
    for (int i = 0; i < 36; i++) begin
      bad += mismatches(exp_bytes, 32'h400 + 16 * i + i % 4, i / 4);
      exp_bytes += i / 4;
    end
    chk(cap_n == exp_bytes, "R3 byte count", cap_n, exp_bytes);
    chk(bad == 0, "R3 byte content and lane order", bad, 0);
    chk(last_n == 32, "R3 last markers", last_n, 32);
    bad = 0;
    for (int i = 0; i < 36; i++)
      if (mem[i * 4 + 2] !== (32'h0009_0000 | (i / 4))) bad++;
    chk(bad == 0, "R4 status writeback", bad, 0);
    bad = 0;
    for (int i = 0; i < 36; i++)
      if (mem[i * 4] !== (32'h0000_0005 | (i << 8))) bad++;
    chk(bad == 0, "R4 control writeback", bad, 0);
    chk(order_err == 0, "R4 status before control", order_err, 0);
    bad = 0;
    for (int i = 0; i < 36; i++)
      if (mem[i * 4 + 1] !== 32'h400 + 16 * i + i % 4 || mem[i * 4 + 3] !== (i + 1) * 16) bad++;
    chk(bad == 0, "R1 buffer/next words untouched", bad, 0);
    chk(cur_desc == 36 * 16, "R2 R7 cur_desc at stop", cur_desc, 36 * 16);
    chk(mem[36 * 4] == 32'h0000_0033 && !busy, "R2 unowned left alone", mem[36 * 4], 32'h33);
    chk(tx_stat == 32'h0081_0000, "R5 status bits after sweep", tx_stat, 32'h0081_0000);
    chk(irq_cnt == 36, "R10 set wins over clear", irq_cnt, 36);

    // R10 clear and irq
    cfg_irq_en = 32'h1 << 23;
    @(negedge clk);
    chk(tx_irq, "R10 irq on enabled bit", tx_irq, 1);
    pulse_clr(32'h1 << 23);
    chk(!tx_irq && tx_stat == 32'h0001_0000, "R10 clear", tx_stat, 32'h0001_0000);
    cfg_irq_en = '0;

    // R8 resume while still unowned: one control read, nothing else
    rc = req_cnt;
    pulse_demand();
    wait_bit(23, "R8 re-read");
    chk(req_cnt == rc + 1 && cap_n == exp_bytes && cur_desc == 36 * 16,
        "R8 re-read owner only", req_cnt - rc, 1);

    // R8 resume after handing it over
    put_desc(36 * 16, 32'h8000_0011, 32'h701, 5, 37 * 16);
    fill_buf(32'h701, 5);
    put_desc(37 * 16, 32'h0, 0, 0, 0);
    pulse_clr(32'h1 << 23);
    start = cap_n;
    pulse_demand();
    wait_bit(23, "R8 resume");
    chk(cap_n == start + 5 && mismatches(start, 32'h701, 5) == 0, "R8 resumed frame bytes", cap_n - start, 5);
    chk(cur_desc == 37 * 16, "R7 next pointer followed", cur_desc, 37 * 16);
    chk(mem[36 * 4 + 2] == 32'h0009_0005, "R4 resumed status", mem[36 * 4 + 2], 32'h0009_0005);

    // R4 with the descriptor interrupt enable low
    cfg_txint_en = 1'b0;
    put_desc(37 * 16, 32'h8000_0000, 32'h720, 3, 38 * 16);
    fill_buf(32'h720, 3);
    put_desc(38 * 16, 32'h0, 0, 0, 0);
    pulse_clr(32'h1 << 23);
    pulse_demand();
    wait_bit(23, "R4 no-int frame");
    chk(mem[37 * 4 + 2] == 32'h0008_0003, "R4 bit 16 follows enable", mem[37 * 4 + 2], 32'h0008_0003);

    // R9 bus error during buffer read
    put_desc(38 * 16, 32'h8000_0000, 32'h8000, 4, 39 * 16);
    start = cap_n;
    pulse_clr(32'h1 << 23);
    pulse_demand();
    wait_bit(24, "R9 bus error flagged");
    chk(cap_n == start && mem[38 * 4] == 32'h8000_0000, "R9 no bytes, no writeback", cap_n - start, 0);
    rc = req_cnt;
    pulse_demand();
    repeat (30) @(negedge clk);
    chk(req_cnt == rc && !tx_valid && tx_stat[24], "R9 halted", req_cnt - rc, 0);

    // R6 first walk after reset uses list base
    cfg_txint_en = 1'b1;
    do_reset();
    chk(tx_stat == 0 && cur_desc == 0 && !busy, "R12 second reset", tx_stat, 0);
    put_desc(32'h800, 32'h8000_0000, 32'h902, 6, 32'h810);
    fill_buf(32'h902, 6);
    put_desc(32'h810, 32'h0, 0, 0, 0);
    cfg_list_base = 32'h800;
    start = cap_n;
    pulse_demand();
    wait_bit(23, "R6 start at list base");
    chk(cur_desc == 32'h810 && cap_n == start + 6 && mismatches(start, 32'h902, 6) == 0,
        "R6 walk from list base", cur_desc, 32'h810);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule